// File: doc/BRIEF.md
# Flash Write-Status Read Generator

This block forms the word a host sees when it reads a flash device while an embedded program or erase is running or suspended. It takes the current operation mode, the bank and sector being read, the bank that holds the running operation, the suspended sector, bit 7 of the word being programmed, the sector-selection window flag, a timeout flag and the array read data. From these it returns either a status word, in which some bits toggle from read to read and some hold steady, or the plain array data. It also drives a ready/busy line.

Two toggle flags advance only on read strobes that actually return status, so software polling with back-to-back reads sees them alternate. A timeout indication is latched and stays visible until a clear command arrives. The output word is combinational from the inputs and this small amount of state, so a read returns its value in the same cycle as the strobe.

Top module: `flash_wstat_gen`

## Requirements
- R1: After reset both toggle flags and the timeout latch are 0. In idle mode (mode 0) dout_o equals array_i and ready_o is 1.
- R2: In program mode (mode 1), a read of the busy bank returns bit7 = inverse of prog_dq7_i, bit6 = the DQ6 toggle flag, bit5 = the timeout latch and bits 4..0 = 0; ready_o is 0.
- R3: In erase mode (mode 2), a read of the busy bank returns bit7 = 0, bit6 = DQ6 toggle flag, bit5 = timeout latch, bit4 = 0, bit3 = inverse of sel_open_i, bit2 = DQ2 toggle flag, bits 1..0 = 0; ready_o is 0.
- R4: In suspend-read mode (mode 3), a read of the suspended sector in the busy bank returns bit7 = 1, bit6 = DQ6 toggle flag (which does not advance), bit2 = DQ2 toggle flag and all other bits 0; ready_o is 1.
- R5: In suspend-read mode, a read of any other sector or bank returns array_i unchanged, with ready_o = 1.
- R6: In suspend-program mode (mode 4), a read of the busy bank returns the same layout as R2 and ready_o is 0.
- R7: In modes 1, 2 and 4, a read of any bank other than busy_bank_i returns array_i unchanged, while ready_o stays 0.
- R8: The DQ6 toggle flag inverts at the clock edge of each strobed status read in modes 1, 2 and 4; the DQ2 toggle flag inverts at the edge of each strobed status read in modes 2 and 3. Neither changes on any other cycle.
- R9: A high tmo_i at a clock edge sets the timeout latch; a high tmo_clr_i at an edge clears it and wins over tmo_i. The latch appears in bit5 only in modes 1, 2 and 4.
- R10: Mode codes 5, 6 and 7 behave as idle: dout_o equals array_i and ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | 0 idle, 1 program, 2 erase, 3 suspend-read, 4 suspend-program |
| rd_stb_i | input | 1 | Read strobe, one cycle per completed read |
| rd_bank_i | input | BANK_W | Bank addressed by the read |
| rd_sect_i | input | SECT_W | Sector addressed by the read |
| busy_bank_i | input | BANK_W | Bank holding the running or suspended operation |
| susp_sect_i | input | SECT_W | Sector whose erase is suspended |
| prog_dq7_i | input | 1 | Bit 7 of the word being programmed |
| sel_open_i | input | 1 | High while further erase sectors may still be queued |
| tmo_i | input | 1 | Operation exceeded its time limit |
| tmo_clr_i | input | 1 | Reset command, clears the timeout latch |
| array_i | input | DATA_W | Array read data |
| dout_o | output | DATA_W | Returned read word |
| ready_o | output | 1 | Ready (1) / busy (0) |

## Verification
The bench builds the block with DATA_W = 8, BANK_W = 2 and SECT_W = 3, so four banks and eight sectors per bank can be swept in full for every one of the eight mode codes. That sweep covers every mix of busy-bank match, suspended-sector match and mode, with strobes dropped on a quarter of the reads so toggle hold is exercised alongside toggle advance. Separate sequences drive the timeout latch through set, hold across modes, clear and the set-with-clear collision.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;

  typedef enum logic [2:0] {
    FM_IDLE    = 3'd0,
    FM_PROG    = 3'd1,
    FM_ERASE   = 3'd2,
    FM_SUSP_RD = 3'd3,
    FM_SUSP_PG = 3'd4
  } fm_mode_e;

  localparam int STAT_W = 8;

  // Modes in which the device is busy and DQ6 advances on status reads
  function automatic logic f_busy_mode(input logic [2:0] m);
    return (m == FM_PROG) || (m == FM_ERASE) || (m == FM_SUSP_PG);
  endfunction

  // Modes in which DQ2 advances on status reads
  function automatic logic f_dq2_mode(input logic [2:0] m);
    return (m == FM_ERASE) || (m == FM_SUSP_RD);
  endfunction

  function automatic logic [STAT_W-1:0] f_status_word(
    input logic [2:0] m,
    input logic       pd7,
    input logic       t6,
    input logic       t2,
    input logic       tmo,
    input logic       win_open
  );
    logic [STAT_W-1:0] w;
    w = '0;
    case (m)
      FM_PROG, FM_SUSP_PG: begin
        w[7] = ~pd7;
        w[6] = t6;
        w[5] = tmo;
      end
      FM_ERASE: begin
        w[6] = t6;
        w[5] = tmo;
        w[3] = ~win_open;
        w[2] = t2;
      end
      FM_SUSP_RD: begin
        w[7] = 1'b1;
        w[6] = t6;
        w[2] = t2;
      end
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/flash_wstat_decode.sv
module flash_wstat_decode #(
  parameter int BANK_W = 2,
  parameter int SECT_W = 8
) (
  input  logic [2:0]        mode,
  input  logic              rd_stb,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [SECT_W-1:0] rd_sect,
  input  logic [BANK_W-1:0] busy_bank,
  input  logic [SECT_W-1:0] susp_sect,
  output logic              status_rd,
  output logic              flip6,
  output logic              flip2,
  output logic              ready
);
  import flash_wstat_pkg::*;

  logic bank_hit;
  logic sect_hit;

  always_comb begin
    bank_hit  = (rd_bank == busy_bank);
    sect_hit  = (rd_sect == susp_sect);
    status_rd = bank_hit && (f_busy_mode(mode) || ((mode == FM_SUSP_RD) && sect_hit));
    flip6     = rd_stb && status_rd && f_busy_mode(mode);
    flip2     = rd_stb && status_rd && f_dq2_mode(mode);
    ready     = !f_busy_mode(mode);
  end

endmodule

// File: rtl/flash_wstat_toggle.sv
module flash_wstat_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (flip) q <= ~q;
  end
endmodule

// File: rtl/flash_wstat_tmo.sv
module flash_wstat_tmo (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
  end
endmodule

// File: rtl/flash_wstat_encode.sv
module flash_wstat_encode #(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        mode,
  input  logic              status_rd,
  input  logic              pd7,
  input  logic              t6,
  input  logic              t2,
  input  logic              tmo,
  input  logic              win_open,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dout
);
  import flash_wstat_pkg::*;

  logic [DATA_W-1:0] stat_word;

  always_comb begin
    stat_word           = '0;
    stat_word[STAT_W-1:0] = f_status_word(mode, pd7, t6, t2, tmo, win_open);
    dout                = status_rd ? stat_word : array_data;
  end

endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 2,
  parameter int SECT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              rd_stb_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [SECT_W-1:0] rd_sect_i,
  input  logic [BANK_W-1:0] busy_bank_i,
  input  logic [SECT_W-1:0] susp_sect_i,
  input  logic              prog_dq7_i,
  input  logic              sel_open_i,
  input  logic              tmo_i,
  input  logic              tmo_clr_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              ready_o
);
  localparam int N_TOG = 2;

  // Named internal events, observed by the bound checker
  logic             status_rd;
  logic             flip6;
  logic             flip2;
  logic             t6_q;
  logic             t2_q;
  logic             tmo_q;
  logic [N_TOG-1:0] tog_flip;
  logic [N_TOG-1:0] tog_q;

  flash_wstat_decode #(.BANK_W(BANK_W), .SECT_W(SECT_W)) u_dec (
    .mode      (mode_i),
    .rd_stb    (rd_stb_i),
    .rd_bank   (rd_bank_i),
    .rd_sect   (rd_sect_i),
    .busy_bank (busy_bank_i),
    .susp_sect (susp_sect_i),
    .status_rd (status_rd),
    .flip6     (flip6),
    .flip2     (flip2),
    .ready     (ready_o)
  );

  assign tog_flip = {flip2, flip6};

  for (genvar g = 0; g < N_TOG; g++) begin : g_tog
    flash_wstat_toggle u_tog (
      .clk   (clk),
      .rst_n (rst_n),
      .flip  (tog_flip[g]),
      .q     (tog_q[g])
    );
  end

  assign t6_q = tog_q[0];
  assign t2_q = tog_q[1];

  flash_wstat_tmo u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (tmo_i),
    .clr   (tmo_clr_i),
    .q     (tmo_q)
  );

  flash_wstat_encode #(.DATA_W(DATA_W)) u_enc (
    .mode       (mode_i),
    .status_rd  (status_rd),
    .pd7        (prog_dq7_i),
    .t6         (t6_q),
    .t2         (t2_q),
    .tmo        (tmo_q),
    .win_open   (sel_open_i),
    .array_data (array_i),
    .dout       (dout_o)
  );

endmodule

// File: rtl/flash_wstat_chk.sv
module flash_wstat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       rd_stb,
  input logic       status_rd,
  input logic       flip6,
  input logic       flip2,
  input logic       t6,
  input logic       t2,
  input logic       tmo_in,
  input logic       tmo_clr,
  input logic       tmo_q,
  input logic       ready,
  input logic       prog_dq7,
  input logic [7:0] dout8,
  input logic [7:0] arr8
);

  p_t6_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flip6 |=> (t6 != $past(t6)));

  p_t2_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flip2 |=> (t2 != $past(t2)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ($stable(t6) && $stable(t2)));

  p_prog_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && mode == 3'd1) |-> (dout8[7] == ~prog_dq7 && dout8[6] == t6 && !ready));

  p_erase_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && mode == 3'd2) |-> (dout8[2] == t2 && dout8[7] == 1'b0 && !ready));

  p_susp_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && mode == 3'd3) |-> (ready && dout8[7] && dout8[6] == t6 && !dout8[5]));

  p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !status_rd |-> (dout8 == arr8));

  p_tmo_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_in && !tmo_clr) |=> tmo_q);

  p_tmo_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_clr |=> !tmo_q);

endmodule

bind flash_wstat_gen flash_wstat_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode_i),
  .rd_stb    (rd_stb_i),
  .status_rd (status_rd),
  .flip6     (flip6),
  .flip2     (flip2),
  .t6        (t6_q),
  .t2        (t2_q),
  .tmo_in    (tmo_i),
  .tmo_clr   (tmo_clr_i),
  .tmo_q     (tmo_q),
  .ready     (ready_o),
  .prog_dq7  (prog_dq7_i),
  .dout8     (dout_o[7:0]),
  .arr8      (array_i[7:0])
);

// File: tb/flash_wstat_gen_tb_top.sv
module flash_wstat_gen_tb_top;
  localparam int DW = 8;
  localparam int BW = 2;
  localparam int SW = 3;
  localparam logic [BW-1:0] BUSY = 2'd2;
  localparam logic [SW-1:0] SUSP = 3'd5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    mode;
  logic          stb;
  logic [BW-1:0] rbank;
  logic [SW-1:0] rsect;
  logic          pd7;
  logic          win;
  logic          tmo;
  logic          clr;
  logic [DW-1:0] arr;
  logic [DW-1:0] dout;
  logic          ready;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  // bench's own state model
  logic m_t6, m_t2, m_tmo;

  always #4 clk = ~clk;

  flash_wstat_gen #(.DATA_W(DW), .BANK_W(BW), .SECT_W(SW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .rd_stb_i    (stb),
    .rd_bank_i   (rbank),
    .rd_sect_i   (rsect),
    .busy_bank_i (BUSY),
    .susp_sect_i (SUSP),
    .prog_dq7_i  (pd7),
    .sel_open_i  (win),
    .tmo_i       (tmo),
    .tmo_clr_i   (tmo_clr_w),
    .array_i     (arr),
    .dout_o      (dout),
    .ready_o     (ready)
  );
  wire tmo_clr_w = clr;

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h (mode=%0d bank=%0d sect=%0d)", tag, got, exp, mode, rbank, rsect);
    end
  endtask

  function automatic logic exp_status(input logic [2:0] m, input logic [BW-1:0] b, input logic [SW-1:0] s);
    if (b != BUSY) return 1'b0;
    if (m == 3'd1 || m == 3'd2 || m == 3'd4) return 1'b1;
    if (m == 3'd3 && s == SUSP) return 1'b1;
    return 1'b0;
  endfunction

  // one read cycle: drive at negedge, check mid-cycle, advance model after the edge
  task automatic do_read(input logic [2:0] m, input logic [BW-1:0] b, input logic [SW-1:0] s,
                         input logic st, input logic p, input logic w,
                         input logic to, input logic cl, input logic [DW-1:0] a);
    logic          is_st;
    logic [DW-1:0] ew;
    logic          er;
    string         tg;
    @(negedge clk);
    mode = m; rbank = b; rsect = s; stb = st; pd7 = p; win = w; tmo = to; clr = cl; arr = a;
    #1;
    is_st = exp_status(m, b, s);
    er    = !(m == 3'd1 || m == 3'd2 || m == 3'd4);
    ew    = '0;
    if (!is_st) begin
      ew = a;
      if (m == 3'd0 || m > 3'd4) tg = "R10";
      else if (m == 3'd3)        tg = "R5";
      else                       tg = "R7";
    end else begin
      case (m)
        3'd1: begin tg = "R2"; ew = {~p, m_t6, m_tmo, 5'b00000}; end
        3'd4: begin tg = "R6"; ew = {~p, m_t6, m_tmo, 5'b00000}; end
        3'd2: begin tg = "R3"; ew = {1'b0, m_t6, m_tmo, 1'b0, ~w, m_t2, 2'b00}; end
        default: begin tg = "R4"; ew = {1'b1, m_t6, 3'b000, m_t2, 2'b00}; end
      endcase
      check("R8 dq6", {7'd0, dout[6]}, {7'd0, m_t6});
      if (m != 3'd3) check("R9 dq5", {7'd0, dout[5]}, {7'd0, m_tmo});
    end
    check(tg, dout, ew);
    check({tg, " ready"}, {7'd0, ready}, {7'd0, er});
    @(posedge clk);
    if (st && is_st && (m == 3'd1 || m == 3'd2 || m == 3'd4)) m_t6 = ~m_t6;
    if (st && is_st && (m == 3'd2 || m == 3'd3))              m_t2 = ~m_t2;
    if (cl)      m_tmo = 1'b0;
    else if (to) m_tmo = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_t6 = 0; m_t2 = 0; m_tmo = 0;
    rst_n = 0; mode = 0; stb = 0; rbank = 0; rsect = 0; pd7 = 0; win = 0;
    tmo = 0; clr = 0; arr = 8'hA5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 idle data", dout, 8'hA5);
    check("R1 ready", {7'd0, ready}, 8'd1);
    rst_n = 1;

    // R1: state from reset seen through the first erase status read
    do_read(3'd2, BUSY, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C);
    check("R1 reset toggles/tmo", dout & 8'h64, 8'h00);

    // full sweep of modes, banks and sectors
    for (int mi = 0; mi < 8; mi++)
      for (int b = 0; b < 4; b++)
        for (int s = 0; s < 8; s++)
          do_read(3'(mi), 2'(b), 3'(s), ((s & 3) != 3), 1'((mi + b + s) & 1),
                  1'((s >> 1) & 1), 1'b0, 1'b0, 8'(mi * 37 + b * 11 + s * 3 + 1));

    // R8: back-to-back program status reads alternate, unstrobed reads hold
    for (int k = 0; k < 6; k++)
      do_read(3'd1, BUSY, 3'(k), (k != 3), 1'b1, 1'b0, 1'b0, 1'b0, 8'hF0);
    // R4/R8: suspend-read keeps DQ6, advances DQ2
    for (int k = 0; k < 4; k++)
      do_read(3'd3, BUSY, SUSP, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0F);

    // R9: timeout latch set, hold across modes, clear, collision
    do_read(3'd2, BUSY, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h11);
    do_read(3'd2, BUSY, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h12);
    check("R9 dq5 latched", {7'd0, dout[5]}, 8'd1);
    do_read(3'd3, BUSY, SUSP, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h13);
    do_read(3'd4, BUSY, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h14);
    check("R9 dq5 before clear", {7'd0, dout[5]}, 8'd1);
    do_read(3'd4, BUSY, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h15);
    check("R9 dq5 cleared", {7'd0, dout[5]}, 8'd0);
    do_read(3'd1, BUSY, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h16);
    do_read(3'd1, BUSY, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h17);
    check("R9 clear wins", {7'd0, dout[5]}, 8'd0);
    do_read(3'd0, 2'd1, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule